// File: doc/BRIEF.md
# Width-Bridging Read Adapter

This block joins a wide read master to a byte-wide memory slave. The master issues one read and sees one answer: a full-width word. Behind the scenes the adapter splits that read into a run of byte reads, one for each byte lane. They go out at consecutive slave addresses on consecutive cycles. The adapter gathers the returned bytes into their lanes and holds the master in wait until the word is complete.

The master width is a parameter of 16 or 32 bits, which gives two or four byte reads per master read. The slave is expected to return data exactly one cycle after it sees its read strobe. Because the strobe is never stalled, the byte reads are fully pipelined. The master address is rounded down to the master word size. It is then captured together with the read strobe on the edge that starts the transaction. The master must hold its request until wait drops. Only reads are handled.

Top module: `bus_width_read_adapter`

## Requirements
- R1: While reset is high and on the first cycle after it, `m_wait` is 1 and `s_read` is 0.
- R2: Each accepted master read produces exactly N = MST_W/8 slave reads, with `s_read` high on N consecutive cycles. The first of these cycles follows the accepting edge.
- R3: The slave addresses run base, base+1, ..., base+N-1 in ascending order, where base is `m_addr` with its low log2(N) bits forced to 0.
- R4: The byte returned for address base+i lands in `m_rdata` bits [8i+7:8i] (little-endian).
- R5: If a request from idle is present at edge E, then `m_wait` is 0 for exactly one cycle, the cycle after edge E+N+1, and `m_rdata` holds the assembled word in that cycle.
- R6: `m_addr` is sampled only at the accepting edge: changing it while `m_wait` is high does not alter the addresses issued or the word returned.
- R7: A request still present at the edge that ends the low-wait cycle is not taken at that edge. A held follow-on request is served with its low-wait cycle N+3 edges after the previous one.
- R8: While idle with `m_read` low, and in the low-wait cycle, `s_read` stays 0.
- R9: The same design serves MST_W=16 (two byte reads) and MST_W=32 (four byte reads).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| m_read | input | 1 | Master read request, held until `m_wait` is 0 |
| m_addr | input | ADDR_W | Master byte address |
| m_wait | output | 1 | Wait to master; 0 for one cycle when data is valid |
| m_rdata | output | MST_W | Assembled read word |
| s_read | output | 1 | Byte read strobe to the slave |
| s_addr | output | ADDR_W | Byte address to the slave |
| s_rdata | input | 8 | Slave data, valid one cycle after `s_read` |

## Verification
The assertions rely on two things: that the slave answers every strobe exactly one cycle later, and that the master holds `m_read` steady until it sees `m_wait` drop. The bench models the slave as a registered byte array indexed by `s_addr`. It drives requests only at falling edges and keeps them asserted through the wait, so both assumptions hold throughout. For both widths it sweeps every address of a 256-byte space, including unaligned ones. On alternate addresses it disturbs `m_addr` mid-transfer, and it also runs held back-to-back requests.

// File: rtl/adapter_pkg.sv
package adapter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } adp_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/subread_issuer.sv
module subread_issuer #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  output logic              s_read,
  output logic [ADDR_W-1:0] s_addr
);
  localparam int CW = $clog2(LANES + 1);
  localparam logic [CW-1:0] LAST = CW'(LANES);

  logic [CW-1:0] issued_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_read     <= 1'b0;
      s_addr     <= '0;
      issued_cnt <= '0;
    end else if (start) begin
      s_read     <= 1'b1;
      s_addr     <= base;
      issued_cnt <= CW'(1);
    end else if (s_read) begin
      if (issued_cnt == LAST) begin
        s_read <= 1'b0;
      end else begin
        s_addr     <= s_addr + ADDR_W'(1);
        issued_cnt <= issued_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/lane_collector.sv
module lane_collector #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    issued,
  input  logic [BYTE_W-1:0]       s_rdata,
  output logic [LANES*BYTE_W-1:0] word,
  output logic                    last
);
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

  logic          pend;
  logic [IW-1:0] ret_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      ret_idx <= '0;
    end else begin
      pend <= issued;
      if (clear)     ret_idx <= '0;
      else if (pend) ret_idx <= ret_idx + IW'(1);
    end
  end

  assign last = pend && (ret_idx == IW'(LANES - 1));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)                              lane_q <= '0;
      else if (pend && ret_idx == IW'(g))   lane_q <= s_rdata;
    end
    assign word[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/bus_width_read_adapter.sv
module bus_width_read_adapter
  import adapter_pkg::*;
#(
  parameter int MST_W  = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_read,
  input  logic [ADDR_W-1:0] m_addr,
  output logic              m_wait,
  output logic [MST_W-1:0]  m_rdata,
  output logic              s_read,
  output logic [ADDR_W-1:0] s_addr,
  input  logic [7:0]        s_rdata
);
  localparam int LANES = MST_W / BYTE_W;
  localparam int LB    = $clog2(LANES);

  adp_state_t        state;
  logic              start;
  logic              last;
  logic [ADDR_W-1:0] base;

  assign start = (state == ST_IDLE) && m_read;
  assign base  = {m_addr[ADDR_W-1:LB], {LB{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      m_wait <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (m_read) state <= ST_BUSY;
        ST_BUSY: if (last) begin
          state  <= ST_DONE;
          m_wait <= 1'b0;
        end
        default: begin
          state  <= ST_IDLE;
          m_wait <= 1'b1;
        end
      endcase
    end
  end

  subread_issuer #(.ADDR_W(ADDR_W), .LANES(LANES)) u_issue (
    .clk(clk), .rst(rst), .start(start), .base(base),
    .s_read(s_read), .s_addr(s_addr)
  );

  lane_collector #(.LANES(LANES), .BYTE_W(BYTE_W)) u_collect (
    .clk(clk), .rst(rst), .clear(start), .issued(s_read),
    .s_rdata(s_rdata), .word(m_rdata), .last(last)
  );
endmodule

// File: rtl/adapter_checker.sv
module adapter_checker #(
  parameter int MST_W  = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              m_wait,
  input logic              s_read,
  input logic [ADDR_W-1:0] s_addr
);
  localparam int LANES = MST_W / 8;
  localparam int LB    = $clog2(LANES);

  logic [3:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (rst)          rd_cnt <= '0;
    else if (!m_wait) rd_cnt <= '0;
    else if (s_read)  rd_cnt <= rd_cnt + 4'd1;
  end

  AST_WAIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !m_wait |=> m_wait); // R5
  AST_READ_COUNT: assert property (@(posedge clk) disable iff (rst)
    !m_wait |-> rd_cnt == 4'(LANES)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (s_read && $past(s_read)) |-> s_addr == $past(s_addr) + ADDR_W'(1)); // R3
  AST_ALIGNED_BASE: assert property (@(posedge clk) disable iff (rst)
    $rose(s_read) |-> s_addr[LB-1:0] == '0); // R3
  AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    !m_wait |-> !s_read); // R8
endmodule

bind bus_width_read_adapter adapter_checker #(.MST_W(MST_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .m_wait(m_wait), .s_read(s_read), .s_addr(s_addr)
);

// File: tb/bus_width_read_adapter_test.sv
module bus_width_read_adapter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit timed_out = 0;

  // 32-bit instance
  logic          rd32 = 0, wt32, sr32;
  logic [AW-1:0] ad32 = '0, sa32;
  logic [31:0]   dt32;
  logic [7:0]    sd32;
  // 16-bit instance
  logic          rd16 = 0, wt16, sr16;
  logic [AW-1:0] ad16 = '0, sa16;
  logic [15:0]   dt16;
  logic [7:0]    sd16;

  bus_width_read_adapter #(.MST_W(32), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .m_read(rd32), .m_addr(ad32), .m_wait(wt32),
    .m_rdata(dt32), .s_read(sr32), .s_addr(sa32), .s_rdata(sd32));
  bus_width_read_adapter #(.MST_W(16), .ADDR_W(AW)) uut_w16 (
    .clk(clk), .rst(rst), .m_read(rd16), .m_addr(ad16), .m_wait(wt16),
    .m_rdata(dt16), .s_read(sr16), .s_addr(sa16), .s_rdata(sd16));

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return (a * 8'd29 + 8'd7) ^ (a >> 3);
  endfunction

  // byte-wide slaves with one-cycle latency
  always @(posedge clk) begin
    if (sr32) sd32 <= mem_f(sa32);
    if (sr16) sd16 <= mem_f(sa16);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int n, input logic [AW-1:0] base);
    logic [31:0] w = '0;
    for (int i = 0; i < n; i++) w[8*i +: 8] = mem_f(base + AW'(i));
    return w;
  endfunction

  task automatic set_req(input bit wide, input bit rd, input logic [AW-1:0] a);
    if (wide) begin rd32 = rd; ad32 = a; end
    else      begin rd16 = rd; ad16 = a; end
  endtask

  // runs until low-wait cycle; returns edges counted, checks issue pattern
  task automatic run_until_done(input bit wide, input logic [AW-1:0] base, input bit perturb,
                                output int edges);
    int n = wide ? 4 : 2;
    int nreads = 0;
    bit wt, sr;
    logic [AW-1:0] sa;
    edges = 0;
    forever begin
      @(posedge clk); edges++;
      @(negedge clk);
      wt = wide ? wt32 : wt16;
      sr = wide ? sr32 : sr16;
      sa = wide ? sa32 : sa16;
      if (sr) begin
        check(sa == base + AW'(nreads), "R3 slave address", sa, base + AW'(nreads));
        nreads++;
      end
      if (perturb && wt) set_req(wide, 1'b1, base ^ AW'(8'hA5));
      if (!wt) break;
      if (edges > 30) begin
        timed_out = 1;
        check(0, "watchdog", edges, 0);
        break;
      end
    end
    check(nreads == n, "R2 sub-read count", nreads, n);
  endtask

  task automatic do_read(input bit wide, input logic [AW-1:0] a, input bit perturb);
    int n = wide ? 4 : 2;
    logic [AW-1:0] base = wide ? {a[AW-1:2], 2'b00} : {a[AW-1:1], 1'b0};
    int edges;
    logic [31:0] got;
    set_req(wide, 1'b1, a);
    run_until_done(wide, base, perturb, edges);
    check(edges == n + 2, "R5 wait timing", edges, n + 2);
    got = wide ? dt32 : {16'h0, dt16};
    check(got == exp_word(n, base), wide ? "R4 R6 R9 data w32" : "R4 R6 R9 data w16",
          got, exp_word(n, base));
    set_req(wide, 1'b0, a);
    @(negedge clk);
    check((wide ? wt32 : wt16) == 1'b1, "R5 single low cycle", wide ? wt32 : wt16, 1);
    check((wide ? sr32 : sr16) == 1'b0, "R8 idle no strobe", wide ? sr32 : sr16, 0);
  endtask

  task automatic back_to_back(input bit wide, input logic [AW-1:0] a, input logic [AW-1:0] b);
    int n = wide ? 4 : 2;
    logic [AW-1:0] bb = wide ? {b[AW-1:2], 2'b00} : {b[AW-1:1], 1'b0};
    logic [AW-1:0] ab = wide ? {a[AW-1:2], 2'b00} : {a[AW-1:1], 1'b0};
    int edges;
    logic [31:0] got;
    set_req(wide, 1'b1, a);
    run_until_done(wide, ab, 1'b0, edges);
    set_req(wide, 1'b1, b);   // held through end of low-wait cycle
    run_until_done(wide, bb, 1'b0, edges);
    check(edges == n + 3, "R7 held follow-on spacing", edges, n + 3);
    got = wide ? dt32 : {16'h0, dt16};
    check(got == exp_word(n, bb), "R7 follow-on data", got, exp_word(n, bb));
    set_req(wide, 1'b0, b);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog expired actual=running expected=finished");
    failures++;
    checks++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wt32 && wt16, "R1 wait in reset", {wt32, wt16}, 2'b11);
    check(!sr32 && !sr16, "R1 no strobe in reset", {sr32, sr16}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(wt32 && wt16 && !sr32 && !sr16, "R1 after reset", {wt32, wt16, sr32, sr16}, 4'b1100);
    repeat (4) begin
      @(negedge clk);
      check(!sr32 && !sr16, "R8 idle without request", {sr32, sr16}, 0);
    end
    for (int w = 0; w < 2; w++)
      for (int a = 0; a < 256; a++) begin
        if (timed_out) break;
        do_read(w[0], AW'(a), a[0]);
      end
    back_to_back(1'b1, 8'h13, 8'h6E);
    back_to_back(1'b0, 8'hFF, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule